// File: doc/BRIEF.md
# Multi-Line Edge Event Detector

This block watches a wide input bus, 256 lines by default, and reports edges on it. Every clock it compares each line with the value that line had at the previous clock. It then raises a one-cycle event bit for that line when the change matches the detection mode chosen for the line. Each line can be set to detect a low-to-high change, a high-to-low change, either change, or nothing. Each line also has a mask bit that silences its event output.

Software sets up the block through a simple word-wide register port. The 2-bit mode fields are packed sixteen to a 32-bit word, and the mask bits thirty-two to a word. The two groups of words sit at fixed byte offsets.

The outputs are the per-line event vector and a single flag that is high whenever any event bit is high. Both are registered.

Top module: `edge_bank`

## Requirements
- R1: After reset, every mode word and every mask word reads 0. This means low-to-high detection on all lines with no line masked. `event_out` and `event_any` are 0.
- R2: A write with `reg_wr_en` replaces the whole 32-bit word. Mode word n (n = 0..15) is at byte offset 0x808 + 4n, and mask word n (n = 0..7) is at 0x848 + 4n. A read with `reg_rd_en` puts the stored word on `reg_rdata` in the cycle after the read edge. `reg_rdata` holds its value while no read is made. A read and a write to the same word at the same edge return the old value.
- R3: An offset outside both ranges, or one that is not a multiple of 4, reads as 0. A write to such an offset changes no register.
- R4: Line r takes its mode from bits [(r mod 16)*2+1 : (r mod 16)*2] of mode word r/16. It takes its mask from bit (r mod 32) of mask word r/32.
- R5: Mode 00 (rising) detects a change from 0 to 1. Suppose the value of `line_in` sampled at clock edge k differs from the value sampled at edge k-1, and the change matches the line's mode. Then `event_out[r]` is 1 from edge k until edge k+1, and 0 otherwise.
- R6: Mode 01 (falling) detects a change from 1 to 0, with the timing of R5.
- R7: Mode 10 (toggle) detects a change in either direction, with the timing of R5.
- R8: Mode 11 is reserved. A line set to 11 never raises its event bit.
- R9: A line whose mask bit is 1 never raises its event bit. Its previous value keeps tracking the input. Clearing the mask later therefore reports no change that happened while the line was masked.
- R10: The first clock edge after reset is released raises no event, whatever the value on `line_in`. The previous values are 0 during reset.
- R11: `event_any` is 1 exactly in the cycles in which at least one bit of `event_out` is 1.
- R12: A register write at edge k governs detection from edge k+1 onward. The comparison made at edge k uses the configuration held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_rd_en | input | 1 | Read strobe for the register port |
| reg_addr | input | 12 | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| line_in | input | 256 | Monitored lines |
| event_out | output | 256 | One-cycle event per line |
| event_any | output | 1 | OR of all event bits |

## Verification
A register write can change a line's mode or mask at the same clock edge at which that line's input change is compared. The bench provokes this in two ways. In directed steps, the mode of line 0 is rewritten at the very edge where line 0 rises. In random steps, mode and mask writes are scattered over cycles in which wide random input patterns change many lines. At each edge, the bench model computes the expected events from the configuration held before the edge and only then applies the write. The design is judged on whether it reports the old-configuration result at that edge and the new-configuration result from the next edge on.

// File: rtl/edge_bank_pkg.sv
package edge_bank_pkg;

  localparam int MODE_BITS = 2;

  typedef enum logic [MODE_BITS-1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } edge_mode_e;

  // Decide whether a change from prev to cur matches the selected mode.
  function automatic logic edge_match(input edge_mode_e mode,
                                      input logic prev,
                                      input logic cur);
    logic res;
    case (mode)
      EDGE_RISE: res = cur & ~prev;
      EDGE_FALL: res = ~cur & prev;
      EDGE_BOTH: res = cur ^ prev;
      default:   res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/edge_bank_regs.sv
module edge_bank_regs
  import edge_bank_pkg::*;
#(
  parameter int                 NUM_LINES = 256,
  parameter int                 DATA_W    = 32,
  parameter int                 ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]  MODE_BASE = 12'h808,
  parameter logic [ADDR_W-1:0]  MASK_BASE = 12'h848
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en_i,
  input  logic                            rd_en_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [NUM_LINES*MODE_BITS-1:0]  mode_flat_o,
  output logic [NUM_LINES-1:0]            mask_flat_o
);

  localparam int MODE_WORDS = (NUM_LINES * MODE_BITS) / DATA_W;
  localparam int MASK_WORDS = NUM_LINES / DATA_W;
  localparam int MODE_IDX_W = (MODE_WORDS > 1) ? $clog2(MODE_WORDS) : 1;
  localparam int MASK_IDX_W = (MASK_WORDS > 1) ? $clog2(MASK_WORDS) : 1;
  localparam int BYTES_W    = DATA_W / 8;
  localparam logic [ADDR_W-1:0] MODE_SPAN = ADDR_W'(MODE_WORDS * BYTES_W);
  localparam logic [ADDR_W-1:0] MASK_SPAN = ADDR_W'(MASK_WORDS * BYTES_W);

  logic [DATA_W-1:0] mode_mem [MODE_WORDS];
  logic [DATA_W-1:0] mask_mem [MASK_WORDS];

  logic [ADDR_W-1:0]     mode_off, mask_off;
  logic                  aligned, mode_hit, mask_hit;
  logic [MODE_IDX_W-1:0] mode_idx;
  logic [MASK_IDX_W-1:0] mask_idx;
  logic [DATA_W-1:0]     rd_word;
  logic [DATA_W-1:0]     rdata_q;

  // Address decode: both ranges are word aligned and bounded.
  assign mode_off = addr_i - MODE_BASE;
  assign mask_off = addr_i - MASK_BASE;
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign mode_hit = aligned && (addr_i >= MODE_BASE) && (mode_off < MODE_SPAN);
  assign mask_hit = aligned && (addr_i >= MASK_BASE) && (mask_off < MASK_SPAN);
  assign mode_idx = mode_off[2 +: MODE_IDX_W];
  assign mask_idx = mask_off[2 +: MASK_IDX_W];

  // Mode words.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < MODE_WORDS; w++) mode_mem[w] <= '0;
    end else if (wr_en_i && mode_hit) begin
      mode_mem[mode_idx] <= wdata_i;
    end
  end

  // Mask words.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < MASK_WORDS; w++) mask_mem[w] <= '0;
    end else if (wr_en_i && mask_hit) begin
      mask_mem[mask_idx] <= wdata_i;
    end
  end

  // Read mux; unmapped offsets give zero.
  always_comb begin
    rd_word = '0;
    if (mode_hit)      rd_word = mode_mem[mode_idx];
    else if (mask_hit) rd_word = mask_mem[mask_idx];
  end

  // Registered read data; the read sees the word as held before the edge.
  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_word;
  end
  assign rdata_o = rdata_q;

  // Flatten the words so that line r's field lands at bit 2r / bit r.
  for (genvar w = 0; w < MODE_WORDS; w++) begin : g_mode_flat
    assign mode_flat_o[w*DATA_W +: DATA_W] = mode_mem[w];
  end
  for (genvar w = 0; w < MASK_WORDS; w++) begin : g_mask_flat
    assign mask_flat_o[w*DATA_W +: DATA_W] = mask_mem[w];
  end

  // R3: unmapped reads return zero
  assert_unmapped_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !mode_hit && !mask_hit) |=> (rdata_o == '0));

  // R2: a mapped mode write lands in the addressed word
  assert_mode_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && mode_hit) |=> (mode_mem[$past(mode_idx)] == $past(wdata_i)));

  // R2: a mapped mask write lands in the addressed word
  assert_mask_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && mask_hit) |=> (mask_mem[$past(mask_idx)] == $past(wdata_i)));

  // R2: read data holds without a read strobe
  assert_rdata_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));

endmodule

// File: rtl/edge_bank_lane.sv
module edge_bank_lane
  import edge_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 arm_i,
  input  logic                 line_i,
  input  logic [MODE_BITS-1:0] mode_i,
  input  logic                 mask_i,
  output logic                 hit_o,
  output logic                 evt_o
);

  logic prev_q;
  logic evt_q;

  // Next-cycle event for this line.
  always_comb hit_o = arm_i & ~mask_i & edge_match(edge_mode_e'(mode_i), prev_q, line_i);

  // The previous value tracks the input even while masked.
  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      prev_q <= line_i;
      evt_q  <= hit_o;
    end
  end
  assign evt_o = evt_q;

  // R9: a masked line stays quiet
  assert_mask_silences_R9: assert property (@(posedge clk) disable iff (rst)
    $past(mask_i) |-> !evt_o);

  // R8: reserved mode never fires
  assert_reserved_silent_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_i) == 2'b11) |-> !evt_o);

  // R5: rising event only on a sampled 0 to 1 change
  assert_rise_change_R5: assert property (@(posedge clk) disable iff (rst)
    (evt_o && $past(mode_i) == 2'b00) |-> ($past(line_i) && !$past(prev_q)));

  // R6: falling event only on a sampled 1 to 0 change
  assert_fall_change_R6: assert property (@(posedge clk) disable iff (rst)
    (evt_o && $past(mode_i) == 2'b01) |-> (!$past(line_i) && $past(prev_q)));

endmodule

// File: rtl/edge_bank_detect.sv
module edge_bank_detect
  import edge_bank_pkg::*;
#(
  parameter int NUM_LINES = 256
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_LINES-1:0]            line_i,
  input  logic [NUM_LINES*MODE_BITS-1:0]  mode_flat_i,
  input  logic [NUM_LINES-1:0]            mask_flat_i,
  output logic [NUM_LINES-1:0]            evt_o,
  output logic                            any_o
);

  logic                 arm_q;
  logic                 any_q;
  logic [NUM_LINES-1:0] hit_v;

  // Arm flag: holds off events for the first edge after reset.
  always_ff @(posedge clk) begin
    if (rst) arm_q <= 1'b0;
    else     arm_q <= 1'b1;
  end

  for (genvar r = 0; r < NUM_LINES; r++) begin : g_lane
    edge_bank_lane u_lane (
      .clk    (clk),
      .rst    (rst),
      .arm_i  (arm_q),
      .line_i (line_i[r]),
      .mode_i (mode_flat_i[r*MODE_BITS +: MODE_BITS]),
      .mask_i (mask_flat_i[r]),
      .hit_o  (hit_v[r]),
      .evt_o  (evt_o[r])
    );
  end

  // Summary flag registered alongside the lane events.
  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= |hit_v;
  end
  assign any_o = any_q;

  // R10: no event on the first edge after reset release
  assert_quiet_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
    !arm_q |=> (evt_o == '0));

  // R11: the summary flag matches the event vector
  assert_any_tracks_R11: assert property (@(posedge clk) disable iff (rst)
    any_o == (|evt_o));

endmodule

// File: rtl/edge_bank.sv
module edge_bank
  import edge_bank_pkg::*;
#(
  parameter int                 NUM_LINES = 256,
  parameter int                 DATA_W    = 32,
  parameter int                 ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]  MODE_BASE = 12'h808,
  parameter logic [ADDR_W-1:0]  MASK_BASE = 12'h848
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic                  reg_rd_en,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic [NUM_LINES-1:0]  line_in,
  output logic [NUM_LINES-1:0]  event_out,
  output logic                  event_any
);

  logic [NUM_LINES*MODE_BITS-1:0] mode_flat;
  logic [NUM_LINES-1:0]           mask_flat;

  edge_bank_regs #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .MODE_BASE (MODE_BASE),
    .MASK_BASE (MASK_BASE)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (reg_wr_en),
    .rd_en_i     (reg_rd_en),
    .addr_i      (reg_addr),
    .wdata_i     (reg_wdata),
    .rdata_o     (reg_rdata),
    .mode_flat_o (mode_flat),
    .mask_flat_o (mask_flat)
  );

  edge_bank_detect #(
    .NUM_LINES (NUM_LINES)
  ) u_detect (
    .clk         (clk),
    .rst         (rst),
    .line_i      (line_in),
    .mode_flat_i (mode_flat),
    .mask_flat_i (mask_flat),
    .evt_o       (event_out),
    .any_o       (event_any)
  );

  // R1: outputs are quiet in the cycle after a reset edge
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (event_out == '0 && !event_any && reg_rdata == '0));

endmodule

// File: tb/edge_bank_tb_top.sv
`timescale 1ns/1ps
module edge_bank_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_wr_en = 1'b0;
  logic         reg_rd_en = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [255:0] line_in = '0;
  logic [255:0] event_out;
  logic         event_any;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // Bench model state.
  logic [31:0]  mode_m [16];
  logic [31:0]  mask_m [8];
  logic [255:0] prev_m;
  bit           armed;
  logic [31:0]  rd_m;

  always #2 clk = ~clk;

  edge_bank dut_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .line_in   (line_in),
    .event_out (event_out),
    .event_any (event_any)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [11:0] a);
    if (a[1:0] != 2'b00) return '0;
    if (a >= 12'h808 && a < 12'h848) return mode_m[(a - 12'h808) >> 2];
    if (a >= 12'h848 && a < 12'h868) return mask_m[(a - 12'h848) >> 2];
    return '0;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    if (a[1:0] != 2'b00) return;
    if (a >= 12'h808 && a < 12'h848) mode_m[(a - 12'h808) >> 2] = d;
    else if (a >= 12'h848 && a < 12'h868) mask_m[(a - 12'h848) >> 2] = d;
  endtask

  function automatic logic [255:0] model_evt(input logic [255:0] cur);
    logic [255:0] res;
    res = '0;
    for (int r = 0; r < 256; r++) begin
      logic [1:0] md;
      logic       mk, e;
      md = mode_m[r/16][(r%16)*2 +: 2];
      mk = mask_m[r/32][r%32];
      case (md)
        2'b00:   e = cur[r] & ~prev_m[r];
        2'b01:   e = ~cur[r] & prev_m[r];
        2'b10:   e = cur[r] ^ prev_m[r];
        default: e = 1'b0;
      endcase
      res[r] = e & ~mk;
    end
    return res;
  endfunction

  // One clock: drive, let the edge pass, update the model, compare.
  task automatic tick(input logic [255:0] lines, input bit we, input bit re,
                      input logic [11:0] a, input logic [31:0] d, input string tag);
    logic [255:0] exp_e;
    line_in   = lines;
    reg_wr_en = we;
    reg_rd_en = re;
    reg_addr  = a;
    reg_wdata = d;
    @(posedge clk);
    exp_e = armed ? model_evt(lines) : '0;
    if (re) rd_m = model_read(a);
    if (we) model_write(a, d);
    prev_m = lines;
    armed  = 1'b1;
    #1;
    chk(event_out == exp_e, tag, event_out, exp_e);
    chk(event_any == (|exp_e), {tag, " R11"}, 256'(event_any), 256'(|exp_e));
    if (re) chk(reg_rdata == rd_m, {tag, " R2"}, 256'(reg_rdata), 256'(rd_m));
    reg_wr_en = 1'b0;
    reg_rd_en = 1'b0;
  endtask

  task automatic do_reset(input logic [255:0] lines);
    line_in = lines;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    for (int w = 0; w < 16; w++) mode_m[w] = '0;
    for (int w = 0; w < 8; w++) mask_m[w] = '0;
    prev_m = '0;
    armed  = 1'b0;
    rd_m   = '0;
    chk(event_out == '0, "R1 events", event_out, '0);
    chk(reg_rdata == '0, "R1 rdata", 256'(reg_rdata), '0);
    rst = 1'b0;
  endtask

  function automatic logic [255:0] bit_at(input int r);
    logic [255:0] v;
    v = '0;
    v[r] = 1'b1;
    return v;
  endfunction

  initial begin
    logic [255:0] cur;
    void'($urandom(32'd20230807));

    // R10: lines high at release, first edge must stay quiet.
    do_reset({256{1'b1}});
    tick({256{1'b1}}, 0, 1, 12'h808, 0, "R10 first edge");
    tick({256{1'b1}}, 0, 1, 12'h864, 0, "R1 mask word 7 reset");
    tick('0, 0, 1, 12'h844, 0, "R1 falling ignored in rise mode");

    // R5: default rising detection on line 3, one-cycle pulse.
    tick(bit_at(3), 0, 0, 0, 0, "R5 rise");
    tick(bit_at(3), 0, 0, 0, 0, "R5 pulse ends");
    tick('0, 0, 0, 0, 0, "R5 fall ignored");

    // R4 / R6: line 3 falling via bits 7:6 of word 0.
    tick('0, 1, 0, 12'h808, 32'h1 << 6, "R4 write mode");
    tick(bit_at(3), 0, 0, 0, 0, "R6 rise ignored");
    tick('0, 0, 0, 0, 0, "R6 fall");

    // R7: toggle mode.
    tick('0, 1, 1, 12'h808, 32'h2 << 6, "R7 write, R2 old read");
    tick(bit_at(3), 0, 1, 12'h808, 0, "R7 rise");
    tick('0, 0, 0, 0, 0, "R7 fall");

    // R8: reserved code.
    tick('0, 1, 0, 12'h808, 32'h3 << 6, "R8 write");
    tick(bit_at(3), 0, 0, 0, 0, "R8 rise");
    tick('0, 0, 0, 0, 0, "R8 fall");

    // R9: masked toggle line, then unmask after a hidden change.
    tick('0, 1, 0, 12'h808, 32'h2 << 6, "R9 toggle mode");
    tick('0, 1, 0, 12'h848, 32'h1 << 3, "R9 mask line 3");
    tick(bit_at(3), 0, 0, 0, 0, "R9 masked rise");
    tick(bit_at(3), 1, 0, 12'h848, 0, "R9 unmask");
    tick(bit_at(3), 0, 0, 0, 0, "R9 no stale event");
    tick('0, 0, 0, 0, 0, "R9 live after unmask");

    // R4: highest line, falling via word 15 bits 31:30, mask word 7 bit 31.
    tick(bit_at(255), 1, 0, 12'h844, 32'h1 << 30, "R4 line 255 mode");
    tick('0, 0, 0, 0, 0, "R6 line 255 fall");
    tick(bit_at(255), 1, 0, 12'h864, 32'h8000_0000, "R4 line 255 rise ignored");
    tick('0, 0, 0, 0, 0, "R9 line 255 masked");

    // R12: rewrite line 0 to falling at the edge where it rises.
    tick('0, 0, 0, 0, 0, "R12 settle");
    tick(bit_at(0), 1, 0, 12'h808, 32'h1, "R12 old config at write edge");
    tick('0, 0, 0, 0, 0, "R12 new config next edge");

    // R3: unmapped and unaligned offsets.
    tick('0, 1, 0, 12'h809, 32'hFFFF_FFFF, "R3 unaligned write");
    tick('0, 0, 1, 12'h808, 0, "R3 word 0 unchanged");
    tick('0, 1, 1, 12'h868, 32'hDEAD_BEEF, "R3 past mask range");
    tick('0, 0, 1, 12'h868, 0, "R3 read past mask range");
    tick('0, 0, 1, 12'h804, 0, "R3 read below mode range");
    tick('0, 0, 1, 12'h80A, 0, "R3 read unaligned");

    // Random phase with overlapping writes and input changes.
    cur = '0;
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      bit          we, re;
      int          sel;
      if ($urandom_range(0, 1) == 0) begin
        for (int k = 0; k < 8; k++) cur[k*32 +: 32] = $urandom;
      end else begin
        for (int k = 0; k < 4; k++) cur[$urandom_range(0, 255)] ^= 1'b1;
      end
      sel = $urandom_range(0, 9);
      if (sel < 5)      a = 12'h808 + 12'($urandom_range(0, 15) * 4);
      else if (sel < 9) a = 12'h848 + 12'($urandom_range(0, 7) * 4);
      else              a = 12'($urandom_range(0, 4095));
      d  = $urandom;
      if (sel >= 5 && sel < 9) d = d & $urandom & $urandom;
      we = ($urandom_range(0, 3) == 0);
      re = ($urandom_range(0, 2) == 0);
      tick(cur, we, re, a, d, "R4 R5 R6 R7 R8 R9 R12 random");
    end

    // R10 again: reset in the middle with lines active.
    do_reset(cur);
    tick(~cur, 0, 1, 12'h820, 0, "R10 second reset first edge");
    tick(cur, 0, 0, 0, 0, "R1 rise-only after reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule